// File: doc/BRIEF.md
# Bit-Plane Binary Inner-Product Array

The block is a digital model of a binary-by-binary vector-matrix array. A matrix of multi-bit elements is stored one bit-plane per row. Each element of `W_BITS` bits takes `W_BITS` separate one-bit rows, so `N_ELEM` elements per column need `N_ELEM*W_BITS` rows of `N_COLS` cells. An input vector arrives one bit-plane per clock, least significant plane first. A full product therefore takes `X_BITS` planes. For each applied plane, every row reports how many of its columns hold a 1 that meets a 1 in the input plane. That count is the AND of weight bit and input bit (unsigned, one-quadrant), summed over all columns. A downstream stage scales and adds these partial counts to form the full products.

Weights enter through two serial shift chains. One chain feeds the even-numbered columns and the other feeds the odd-numbered columns. A write request copies the assembled word into one selected row. A separate serial readback path lets a test unload any stored row, column 0 first.

The control is a three-state machine: IDLE, RUN and WRITE.
- IDLE to WRITE: a write is pending. WRITE always returns to IDLE after one cycle, and the row is stored at the end of the WRITE cycle.
- IDLE to RUN: no write is pending and `x_valid` is high. This applies plane 0. If `X_BITS` is 1, the state stays in IDLE instead.
- RUN to RUN: a further plane is applied, or no plane arrives in that cycle.
- RUN to IDLE: plane `X_BITS-1` is applied.

A write request that arrives during RUN is held until the sequence completes.

Top module: `bitplane_ipa`

## Requirements
- R1: After reset, `cnt_valid` is 0, every row count is 0, `rd_bit` is 0, and every stored weight bit is 0.
- R2: After `N_COLS/2` cycles with `ld_shift` high, a one-cycle `wr_req` with row `r` stores the assembled word in row `r`. Column 2k takes the k-th bit shifted into `ld_even_in` and column 2k+1 takes the k-th bit shifted into `ld_odd_in`, counting from the first bit shifted (k=0). The row is stored by the third rising edge after the edge that samples `wr_req`.
- R3: One cycle after a plane is accepted, `cnt_valid` is 1. Row `r`'s count, at bits `[r*CW +: CW]` of `cnt_rows` with `CW = ceil(log2(N_COLS+1))`, equals the number of columns where stored bit and input bit are both 1. A count never exceeds `N_COLS`.
- R4: Within a sequence, `cnt_plane` reports 0, 1, ... `X_BITS-1` for successive accepted planes. After plane `X_BITS-1` the machine is in IDLE, and the next accepted plane is plane 0 again.
- R5: A `wr_req` during RUN does not alter the counts of the running sequence. The row takes the new value only after the last plane, and later sequences use it.
- R6: Computing never changes stored weights. A row read back after computation equals what was written.
- R7: Pulsing `rd_load` with row `r` makes `rd_bit` show column 0 of that row. After c cycles of `rd_shift`, `rd_bit` shows column c. Without `rd_load` or `rd_shift`, `rd_bit` holds its value.
- R8: A plane offered in IDLE while a write is pending is ignored: no `cnt_valid` follows it.
- R9: The word written is the shift-chain contents at the cycle of `wr_req`. Shifting after the request does not change what is stored.
- R10: A cycle with `x_valid` low inside a sequence produces no `cnt_valid`, and the plane index resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_shift | input | 1 | Advance both weight shift chains |
| ld_even_in | input | 1 | Serial bit for even columns |
| ld_odd_in | input | 1 | Serial bit for odd columns |
| wr_req | input | 1 | Request to store assembled word |
| wr_row | input | RW | Target row of the write |
| x_valid | input | 1 | Input plane present this cycle |
| x_plane | input | N_COLS | Input bit-plane, one bit per column |
| rd_load | input | 1 | Load a row into the readback chain |
| rd_shift | input | 1 | Shift readback chain by one column |
| rd_row | input | RW | Row selected for readback |
| rd_bit | output | 1 | Current readback column bit |
| cnt_valid | output | 1 | Row counts updated this cycle |
| cnt_plane | output | JW | Plane index of the current counts |
| cnt_rows | output | ROWS*CW | Per-row counts, row r at [r*CW +: CW] |

## Verification
The bench builds the array with `N_COLS=8`, `N_ELEM=2`, `W_BITS=3` and `X_BITS=4`. This gives six rows, a row count that is not a power of two, so the row decoders see unused select values. It also gives 4-bit counts, so a full row meeting a full plane reaches the top count of 8. With four planes, back-to-back sequences exercise the wrap of the plane index. The pending-write hold and the ignored plane in IDLE are each reached within one short sequence.

// File: rtl/ipa_pkg.sv
package ipa_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_WRITE = 2'd2
    } ipa_state_t;
endpackage

// File: rtl/ipa_loader.sv
// Two serial chains assemble one row word: even columns and odd columns.
module ipa_loader #(
    parameter int N_COLS = 16,
    localparam int HALF = N_COLS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_shift,
    input  logic              ld_even_in,
    input  logic              ld_odd_in,
    output logic [N_COLS-1:0] ld_word
);
    logic [HALF-1:0] even_q;
    logic [HALF-1:0] odd_q;

    // New bits enter at the top, so the first bit shifted settles at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
        end else if (ld_shift) begin
            even_q <= {ld_even_in, even_q[HALF-1:1]};
            odd_q  <= {ld_odd_in,  odd_q[HALF-1:1]};
        end
    end

    for (genvar k = 0; k < HALF; k++) begin : g_lane
        assign ld_word[2*k]   = even_q[k];
        assign ld_word[2*k+1] = odd_q[k];
    end
endmodule

// File: rtl/ipa_rowcount.sv
// Per-row AND-and-count of stored bits against the current input plane.
module ipa_rowcount #(
    parameter int N_COLS = 16,
    parameter int ROWS   = 16,
    localparam int CW = $clog2(N_COLS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fire,
    input  logic [N_COLS-1:0]      x_plane,
    input  logic [ROWS*N_COLS-1:0] wmem,
    output logic [ROWS*CW-1:0]     cnt_rows
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [CW-1:0] sum;
        logic [CW-1:0] cnt_q;

        always_comb begin
            sum = '0;
            for (int c = 0; c < N_COLS; c++) begin
                sum = sum + CW'(wmem[r*N_COLS+c] & x_plane[c]);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)    cnt_q <= '0;
            else if (fire) cnt_q <= sum;
        end

        assign cnt_rows[r*CW +: CW] = cnt_q;
    end
endmodule

// File: rtl/ipa_readback.sv
// Serial unload of one stored row, column 0 first.
module ipa_readback #(
    parameter int N_COLS = 16,
    parameter int ROWS   = 16,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_load,
    input  logic                   rd_shift,
    input  logic [RW-1:0]          rd_row,
    input  logic [ROWS*N_COLS-1:0] wmem,
    output logic                   rd_bit
);
    logic [N_COLS-1:0] pick;
    logic [N_COLS-1:0] chain_q;

    always_comb begin
        pick = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (rd_row == RW'(r)) pick = wmem[r*N_COLS +: N_COLS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        chain_q <= '0;
        else if (rd_load)  chain_q <= pick;
        else if (rd_shift) chain_q <= {1'b0, chain_q[N_COLS-1:1]};
    end

    assign rd_bit = chain_q[0];
endmodule

// File: rtl/bitplane_ipa.sv
module bitplane_ipa
    import ipa_pkg::*;
#(
    parameter int N_COLS = 16,
    parameter int N_ELEM = 4,
    parameter int W_BITS = 4,
    parameter int X_BITS = 4,
    localparam int ROWS = N_ELEM * W_BITS,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW   = $clog2(N_COLS + 1),
    localparam int JW   = (X_BITS > 1) ? $clog2(X_BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_shift,
    input  logic              ld_even_in,
    input  logic              ld_odd_in,
    input  logic              wr_req,
    input  logic [RW-1:0]     wr_row,
    input  logic              x_valid,
    input  logic [N_COLS-1:0] x_plane,
    input  logic              rd_load,
    input  logic              rd_shift,
    input  logic [RW-1:0]     rd_row,
    output logic              rd_bit,
    output logic              cnt_valid,
    output logic [JW-1:0]     cnt_plane,
    output logic [ROWS*CW-1:0] cnt_rows
);
    ipa_state_t state, state_nx;
    logic [JW-1:0]          pl_idx, pl_nx;
    logic                   fire;
    logic                   do_write;
    logic                   last_pl;
    logic                   pend;
    logic [RW-1:0]          pend_row;
    logic [N_COLS-1:0]      pend_word;
    logic [N_COLS-1:0]      ld_word;
    logic [ROWS*N_COLS-1:0] wmem;

    assign last_pl = (pl_idx == JW'(X_BITS - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pl_idx <= '0;
        end else begin
            state  <= state_nx;
            pl_idx <= pl_nx;
        end
    end

    // Next state and outputs of the controller
    always_comb begin
        state_nx = state;
        pl_nx    = pl_idx;
        fire     = 1'b0;
        do_write = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (pend) begin
                    state_nx = S_WRITE;
                end else if (x_valid) begin
                    fire     = 1'b1;
                    pl_nx    = last_pl ? '0 : pl_idx + 1'b1;
                    state_nx = last_pl ? S_IDLE : S_RUN;
                end
            end
            S_RUN: begin
                if (x_valid) begin
                    fire     = 1'b1;
                    pl_nx    = last_pl ? '0 : pl_idx + 1'b1;
                    state_nx = last_pl ? S_IDLE : S_RUN;
                end
            end
            S_WRITE: begin
                do_write = 1'b1;
                state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Pending write, captured with the word present at request time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_row  <= '0;
            pend_word <= '0;
        end else if (wr_req) begin
            pend      <= 1'b1;
            pend_row  <= wr_row;
            pend_word <= ld_word;
        end else if (do_write) begin
            pend      <= 1'b0;
        end
    end

    // Weight storage, changed only in WRITE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmem <= '0;
        end else if (do_write) begin
            for (int r = 0; r < ROWS; r++) begin
                if (pend_row == RW'(r)) wmem[r*N_COLS +: N_COLS] <= pend_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_valid <= 1'b0;
            cnt_plane <= '0;
        end else begin
            cnt_valid <= fire;
            if (fire) cnt_plane <= pl_idx;
        end
    end

    ipa_loader #(.N_COLS(N_COLS)) i_loader (
        .clk(clk), .rst_n(rst_n), .ld_shift(ld_shift),
        .ld_even_in(ld_even_in), .ld_odd_in(ld_odd_in), .ld_word(ld_word)
    );

    ipa_rowcount #(.N_COLS(N_COLS), .ROWS(ROWS)) i_rowcount (
        .clk(clk), .rst_n(rst_n), .fire(fire), .x_plane(x_plane),
        .wmem(wmem), .cnt_rows(cnt_rows)
    );

    ipa_readback #(.N_COLS(N_COLS), .ROWS(ROWS)) i_readback (
        .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_shift(rd_shift),
        .rd_row(rd_row), .wmem(wmem), .rd_bit(rd_bit)
    );
endmodule

// File: rtl/bitplane_ipa_chk.sv
module bitplane_ipa_chk
    import ipa_pkg::*;
#(
    parameter int N_COLS = 16,
    parameter int ROWS   = 16,
    parameter int X_BITS = 4,
    localparam int CW = $clog2(N_COLS + 1),
    localparam int JW = (X_BITS > 1) ? $clog2(X_BITS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   x_valid,
    input logic                   cnt_valid,
    input logic [JW-1:0]          cnt_plane,
    input logic [ROWS*CW-1:0]     cnt_rows,
    input ipa_state_t             state,
    input logic [ROWS*N_COLS-1:0] wmem,
    input logic                   rd_load,
    input logic                   rd_shift,
    input logic                   rd_bit
);
    AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> $past(x_valid)); // R3

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                AST_COUNT_BOUND: assert (cnt_rows[r*CW +: CW] <= CW'(N_COLS)); // R3
            end
        end
    end

    AST_FIRST_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && cnt_plane == '0) |-> $past(state == S_IDLE)); // R4

    AST_LATER_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && cnt_plane != '0) |-> $past(state == S_RUN)); // R4

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && cnt_plane == JW'(X_BITS - 1)) |-> state == S_IDLE); // R4

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_WRITE |=> state == S_IDLE); // R5

    AST_WEIGHTS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_WRITE |=> $stable(wmem)); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_load && !rd_shift) |=> $stable(rd_bit)); // R7
endmodule

bind bitplane_ipa bitplane_ipa_chk #(
    .N_COLS(N_COLS), .ROWS(ROWS), .X_BITS(X_BITS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .cnt_valid(cnt_valid),
    .cnt_plane(cnt_plane), .cnt_rows(cnt_rows), .state(state), .wmem(wmem),
    .rd_load(rd_load), .rd_shift(rd_shift), .rd_bit(rd_bit)
);

// File: tb/test_bitplane_ipa.sv
module test_bitplane_ipa;
    localparam int TN = 8, TM = 2, TI = 3, TJ = 4;
    localparam int ROWS = TM * TI, RW = 3, CW = 4, JW = 2;

    // Each entry: {input plane, expected plane index}
    localparam logic [TN+JW-1:0] TBL [8] = '{
        {8'hFF, 2'd0}, {8'h00, 2'd1}, {8'hAA, 2'd2}, {8'h55, 2'd3},
        {8'h0F, 2'd0}, {8'hC3, 2'd1}, {8'h81, 2'd2}, {8'h7E, 2'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld_shift = 0, ld_even_in = 0, ld_odd_in = 0, wr_req = 0;
    logic [RW-1:0] wr_row = '0, rd_row = '0;
    logic x_valid = 0, rd_load = 0, rd_shift = 0;
    logic [TN-1:0] x_plane = '0;
    logic rd_bit, cnt_valid;
    logic [JW-1:0] cnt_plane;
    logic [ROWS*CW-1:0] cnt_rows;

    logic [TN-1:0] wm [ROWS];
    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    bitplane_ipa #(.N_COLS(TN), .N_ELEM(TM), .W_BITS(TI), .X_BITS(TJ)) i_bitplane_ipa (
        .clk(clk), .rst_n(rst_n), .ld_shift(ld_shift), .ld_even_in(ld_even_in),
        .ld_odd_in(ld_odd_in), .wr_req(wr_req), .wr_row(wr_row), .x_valid(x_valid),
        .x_plane(x_plane), .rd_load(rd_load), .rd_shift(rd_shift), .rd_row(rd_row),
        .rd_bit(rd_bit), .cnt_valid(cnt_valid), .cnt_plane(cnt_plane), .cnt_rows(cnt_rows)
    );

    function automatic int pc(input logic [TN-1:0] a, input logic [TN-1:0] b);
        int s = 0;
        for (int c = 0; c < TN; c++) s += int'(a[c] & b[c]);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [TN-1:0] x, input int idx);
        chk(cnt_valid == 1'b1, {req, " valid"}, int'(cnt_valid), 1);
        chk(int'(cnt_plane) == idx, {req, " plane index"}, int'(cnt_plane), idx);
        for (int r = 0; r < ROWS; r++)
            chk(int'(cnt_rows[r*CW +: CW]) == pc(wm[r], x), {req, " row count"},
                int'(cnt_rows[r*CW +: CW]), pc(wm[r], x));
    endtask

    task automatic load_shift(input logic [TN-1:0] w);
        for (int k = 0; k < TN/2; k++) begin
            @(negedge clk);
            ld_even_in = w[2*k];
            ld_odd_in  = w[2*k+1];
            ld_shift   = 1'b1;
        end
        @(negedge clk);
        ld_shift = 1'b0;
    endtask

    task automatic write_row(input int r, input logic [TN-1:0] w);
        load_shift(w);
        wr_req = 1'b1;
        wr_row = RW'(r);
        @(negedge clk);
        wr_req = 1'b0;
        repeat (3) @(negedge clk);
        wm[r] = w;
    endtask

    task automatic readback(input int r, input logic [TN-1:0] w, input string req);
        @(negedge clk);
        rd_load = 1'b1;
        rd_row  = RW'(r);
        @(negedge clk);
        rd_load = 1'b0;
        for (int c = 0; c < TN; c++) begin
            chk(rd_bit == w[c], req, int'(rd_bit), int'(w[c]));
            rd_shift = 1'b1;
            @(negedge clk);
        end
        rd_shift = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) wm[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(cnt_valid == 1'b0, "R1 valid", int'(cnt_valid), 0);
        chk(cnt_rows == '0, "R1 counts", int'(cnt_rows), 0);
        chk(rd_bit == 1'b0, "R1 rd_bit", int'(rd_bit), 0);
        readback(0, '0, "R1 stored zero");

        // R2, R7: load every row and read it back
        write_row(0, 8'hFF); write_row(1, 8'h00); write_row(2, 8'hA5);
        write_row(3, 8'h3C); write_row(4, 8'h81); write_row(5, 8'h7E);
        for (int r = 0; r < ROWS; r++) readback(r, wm[r], "R2 R7 readback");

        // R3, R4: table of back-to-back sequences
        @(negedge clk);
        x_valid = 1'b1;
        x_plane = TBL[0][TN+JW-1:JW];
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_out("R3 R4 table", TBL[i][TN+JW-1:JW], int'(TBL[i][JW-1:0]));
            if (i < 7) x_plane = TBL[i+1][TN+JW-1:JW];
            else       x_valid = 1'b0;
        end

        // R6: weights unchanged by computing
        readback(3, wm[3], "R6 after compute");

        // R5, R9: write requested mid-run, chain disturbed afterwards
        load_shift(8'h5A);
        x_valid = 1'b1; x_plane = 8'hFF;
        @(negedge clk);
        check_out("R5 plane0 old", 8'hFF, 0);
        x_plane = 8'h0F; wr_req = 1'b1; wr_row = 3'd2;
        @(negedge clk);
        check_out("R5 plane1 old", 8'h0F, 1);
        wr_req = 1'b0; x_plane = 8'hF0;
        ld_shift = 1'b1; ld_even_in = 1'b1; ld_odd_in = 1'b1;
        @(negedge clk);
        check_out("R5 plane2 old", 8'hF0, 2);
        x_plane = 8'h33;
        @(negedge clk);
        check_out("R5 plane3 old", 8'h33, 3);
        x_valid = 1'b0; ld_shift = 1'b0;
        repeat (3) @(negedge clk);
        wm[2] = 8'h5A;
        readback(2, 8'h5A, "R9 snapshot");
        @(negedge clk);
        x_valid = 1'b1; x_plane = 8'hFF;
        @(negedge clk);
        check_out("R5 new weights", 8'hFF, 0);
        x_valid = 1'b0;
        // finish this sequence so plane index restarts
        for (int p = 1; p < TJ; p++) begin
            x_valid = 1'b1; x_plane = 8'h5A;
            @(negedge clk);
            check_out("R5 new weights run", 8'h5A, p);
        end
        x_valid = 1'b0;

        // R8: plane offered while a write is pending in IDLE
        load_shift(8'hC3);
        wr_req = 1'b1; wr_row = 3'd4;
        @(negedge clk);
        wr_req = 1'b0; x_valid = 1'b1; x_plane = 8'hFF;
        @(negedge clk);
        chk(cnt_valid == 1'b0, "R8 ignored plane", int'(cnt_valid), 0);
        x_valid = 1'b0;
        repeat (2) @(negedge clk);
        wm[4] = 8'hC3;
        readback(4, 8'hC3, "R8 write done");

        // R10: gap inside a sequence
        @(negedge clk);
        x_valid = 1'b1; x_plane = 8'h96;
        @(negedge clk);
        check_out("R10 plane0", 8'h96, 0);
        x_valid = 1'b0;
        @(negedge clk);
        chk(cnt_valid == 1'b0, "R10 gap", int'(cnt_valid), 0);
        x_valid = 1'b1; x_plane = 8'h69;
        @(negedge clk);
        check_out("R10 plane1", 8'h69, 1);
        x_plane = 8'hF0;
        @(negedge clk);
        check_out("R10 plane2", 8'hF0, 2);
        x_plane = 8'h0F;
        @(negedge clk);
        check_out("R10 plane3", 8'h0F, 3);
        x_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule